// File: doc/BRIEF.md
# Window-Crossing Write Halt Gate

This block sits on the write-address path between an inbound bus port and a downstream memory master. Each posted write request passes straight through, with no added register. The block remembers the address of the last write it let through. It compares each new request against that address inside a naturally aligned window whose size is a power of two, picked at run time by a bit index in a 32-bit control word.

When a request falls in a different window while earlier writes still await their responses, the gate stalls it. Because requests stay in order, every later request waits behind it. The request is released once the response count has drained to zero. Responses are observed by snooping the write-response handshake; the gate does not drive that channel.

A master enable in the control word turns the gate into a plain wire when it is clear. The first write seen after reset, or after the enable is set, only records its window.

Top module: `win_halt_gate`

## Requirements
- R1: After reset no window is recorded and nothing is outstanding. With no request present, `m_awvalid` is low and `s_awready` follows `m_awready`. The first request passes without waiting.
- R2: A request that is not halted passes through unchanged. `m_awvalid` equals `s_awvalid`, `m_awaddr` equals `s_awaddr`, and `s_awready` equals `m_awready`. Each address reaches the downstream side exactly once, in order.
- R3: When the enable bit (control bit 31) is 0, no request is ever halted.
- R4: The window index is control bits [5:0], and the window size is 2^index bytes. A request whose address matches the last passed address in every bit at or above the index passes even while responses are pending.
- R5: A request whose address differs from the last passed address in any bit at or above the index is held while any write is outstanding. While held, `s_awready` and `m_awvalid` are both low.
- R6: A held request is released in the first cycle in which the outstanding count is zero. That is the cycle after the last pending response handshake.
- R7: The first request after the enable bit goes from 0 to 1 passes without waiting, even if writes are outstanding. It records its window.
- R8: A new index value applies to the very next comparison. Writes already outstanding are not affected.
- R9: An index value equal to or above the address width means the window covers the whole address space, so no request is halted.
- R10: The outstanding count rises by one per accepted request and falls by one per response handshake. When both happen in the same cycle, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | 32 | Control word: bit 31 enable, bits [5:0] window bit index |
| s_awvalid | input | 1 | Upstream write-address valid |
| s_awready | output | 1 | Upstream write-address ready |
| s_awaddr | input | ADDR_W | Upstream write address |
| m_awvalid | output | 1 | Downstream write-address valid |
| m_awready | input | 1 | Downstream write-address ready |
| m_awaddr | output | ADDR_W | Downstream write address |
| b_valid | input | 1 | Snooped write-response valid |
| b_ready | input | 1 | Snooped write-response ready |

## Verification
The checker assumes that a response handshake is only seen for a write the gate has already passed. It also assumes the number of writes in flight never goes above MAX_OUT, so the counter steps without wrapping. The upstream side must keep a stalled request's valid and address steady until it is accepted. The bench meets these conditions by pulsing the response handshake only for writes it has already sent, keeping at most five writes in flight, and never changing a held request.

// File: rtl/win_gate_pkg.sv
package win_gate_pkg;
   localparam int CTRL_W = 32;
   localparam int EN_POS = 31;
   localparam int IDX_W  = 6;

   typedef struct packed {
      logic             enable;
      logic [IDX_W-1:0] bit_idx;
   } gate_cfg_t;

   function automatic gate_cfg_t unpack_cfg(input logic [CTRL_W-1:0] word);
      gate_cfg_t c;
      c.enable  = word[EN_POS];
      c.bit_idx = word[IDX_W-1:0];
      return c;
   endfunction
endpackage

// File: rtl/wg_window_cmp.sv
module wg_window_cmp #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [ADDR_W-1:0] addr_new,
   input  logic [ADDR_W-1:0] addr_old,
   output logic              differ
);
   localparam int POS_W = IDX_W + 1;

   logic [ADDR_W-1:0] diff_bits;

   // One compare slice per address bit; a slice counts only at or above the index.
   for (genvar i = 0; i < ADDR_W; i++) begin : g_slice
      localparam logic [POS_W-1:0] POS = POS_W'(i);
      assign diff_bits[i] = (addr_new[i] ^ addr_old[i]) & (POS >= {1'b0, bit_idx});
   end

   assign differ = |diff_bits;
endmodule

// File: rtl/wg_outstanding.sv
module wg_outstanding #(
   parameter int MAX_OUT = 16,
   parameter int CW      = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] count,
   output logic          idle
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && !dec) begin
         count <= count + CW'(1);
      end else if (!inc && dec) begin
         count <= count - CW'(1);
      end
   end

   assign idle = (count == '0);
endmodule

// File: rtl/wg_window_track.sv
module wg_window_track #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              take,
   input  logic [ADDR_W-1:0] addr,
   output logic              have_last,
   output logic [ADDR_W-1:0] last_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_addr <= '0;
      end else if (!enable) begin
         have_last <= 1'b0;
      end else if (take) begin
         have_last <= 1'b1;
         last_addr <= addr;
      end
   end
endmodule

// File: rtl/win_halt_gate.sv
module win_halt_gate
   import win_gate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MAX_OUT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_ctrl,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [ADDR_W-1:0] m_awaddr,
   input  logic              b_valid,
   input  logic              b_ready
);
   localparam int CNT_W = $clog2(MAX_OUT + 1);

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
      $error("win_halt_gate: ADDR_W must lie in 2..64");
   end
   if (MAX_OUT < 1) begin : g_bad_max_out
      $error("win_halt_gate: MAX_OUT must be at least 1");
   end

   gate_cfg_t         cfg;
   logic              cfg_unused;
   logic              have_last;
   logic [ADDR_W-1:0] last_addr;
   logic              differ;
   logic              crossing;
   logic              halt;
   logic              aw_fire;
   logic              b_fire;
   logic [CNT_W-1:0]  out_cnt;
   logic              out_idle;

   assign cfg        = unpack_cfg(cfg_ctrl);
   assign cfg_unused = ^cfg_ctrl[30:6];

   wg_window_cmp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cmp (
      .bit_idx  (cfg.bit_idx),
      .addr_new (s_awaddr),
      .addr_old (last_addr),
      .differ   (differ)
   );

   assign crossing  = cfg.enable & have_last & differ;
   assign halt      = s_awvalid & crossing & ~out_idle;
   assign m_awvalid = s_awvalid & ~halt;
   assign s_awready = m_awready & ~halt;
   assign m_awaddr  = s_awaddr;
   assign aw_fire   = m_awvalid & m_awready;
   assign b_fire    = b_valid & b_ready;

   wg_window_track #(.ADDR_W(ADDR_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (cfg.enable),
      .take      (aw_fire),
      .addr      (s_awaddr),
      .have_last (have_last),
      .last_addr (last_addr)
   );

   wg_outstanding #(.MAX_OUT(MAX_OUT), .CW(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (aw_fire),
      .dec   (b_fire),
      .count (out_cnt),
      .idle  (out_idle)
   );
endmodule

// File: rtl/win_halt_gate_chk.sv
module win_halt_gate_chk #(
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_en,
   input logic          s_awvalid,
   input logic          s_awready,
   input logic          m_awvalid,
   input logic          m_awready,
   input logic          aw_fire,
   input logic          b_fire,
   input logic [CW-1:0] cnt
);
   AST_HS_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready) |-> (m_awvalid && m_awready)); // R2

   AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && s_awvalid) |-> m_awvalid); // R3

   AST_HALT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && !m_awvalid) |-> (cnt != '0)); // R5

   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && s_awvalid) |-> m_awvalid); // R6

   AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_fire && !b_fire) |=> (cnt == $past(cnt) + CW'(1))); // R10

   AST_CNT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_fire && b_fire) |=> $stable(cnt)); // R10
endmodule

bind win_halt_gate win_halt_gate_chk #(.CW(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_ctrl[31]),
   .s_awvalid (s_awvalid),
   .s_awready (s_awready),
   .m_awvalid (m_awvalid),
   .m_awready (m_awready),
   .aw_fire   (aw_fire),
   .b_fire    (b_fire),
   .cnt       (out_cnt)
);

// File: tb/sim_win_halt_gate.sv
`timescale 1ns/1ps
module sim_win_halt_gate;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg_ctrl = '0;
   logic          s_awvalid = 1'b0;
   logic          s_awready;
   logic [AW-1:0] s_awaddr = '0;
   logic          m_awvalid;
   logic          m_awready = 1'b1;
   logic [AW-1:0] m_awaddr;
   logic          b_valid = 1'b0;
   logic          b_ready = 1'b1;

   int errs = 0;
   int checks = 0;
   logic [AW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   win_halt_gate #(.ADDR_W(AW), .MAX_OUT(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
      .b_valid(b_valid), .b_ready(b_ready)
   );

   function automatic logic [31:0] mk(input logic en, input logic [5:0] idx);
      return {en, 25'd0, idx};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic bpulse;
      b_valid = 1'b1;
      tick();
      b_valid = 1'b0;
   endtask

   // Driver: queue the expected address, present the request, count stall cycles.
   task automatic send(input logic [AW-1:0] addr, input int exp_wait, input string req);
      int waited = 0;
      exp_q.push_back(addr);
      s_awaddr  = addr;
      s_awvalid = 1'b1;
      #1;
      while (!s_awready && waited < 50) begin
         tick();
         waited++;
      end
      tick();
      s_awvalid = 1'b0;
      chk(waited == exp_wait, req, "stall cycles", waited, exp_wait);
   endtask

   // Present a request that must stay held for n cycles; it is left pending.
   task automatic hold_blocked(input logic [AW-1:0] addr, input int n, input string req);
      exp_q.push_back(addr);
      s_awaddr  = addr;
      s_awvalid = 1'b1;
      #1;
      for (int i = 0; i < n; i++) begin
         chk(!s_awready && !m_awvalid, req, "held request",
             {s_awready, m_awvalid}, 0);
         tick();
      end
   endtask

   task automatic expect_release(input string req);
      chk(s_awready && m_awvalid, req, "release after drain", {s_awready, m_awvalid}, 3);
      tick();
      s_awvalid = 1'b0;
   endtask

   // Monitor: every downstream acceptance pops and compares one expected address (R2).
   always @(negedge clk) begin
      if (rst_n && m_awvalid && m_awready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected downstream write", m_awaddr, 0);
         end else begin
            logic [AW-1:0] e;
            e = exp_q.pop_front();
            chk(m_awaddr == e, "R2", "downstream address order", m_awaddr, e);
         end
      end
   end

   initial begin
      #1000000;
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R1: idle outputs while in reset
      chk(!m_awvalid && s_awready, "R1", "idle outputs in reset", {m_awvalid, s_awready}, 1);
      rst_n = 1'b1;
      cfg_ctrl = mk(1'b1, 6'd12);
      tick();
      chk(!m_awvalid && s_awready, "R1", "idle outputs after reset", {m_awvalid, s_awready}, 1);

      // R1/R4: first write passes, same 4 KiB window passes with one outstanding
      send(32'h0000_1000, 0, "R1");
      send(32'h0000_1FF0, 0, "R4");
      // R5/R6: crossing with two outstanding is held until both responses return
      hold_blocked(32'h0000_2000, 3, "R5");
      bpulse();
      chk(!s_awready && !m_awvalid, "R6", "still held with one pending", {s_awready, m_awvalid}, 0);
      bpulse();
      expect_release("R6");

      // R10: simultaneous accept and response keeps the count at one
      b_valid = 1'b1;
      send(32'h0000_2004, 0, "R10");
      b_valid = 1'b0;
      hold_blocked(32'h0000_5000, 2, "R10");
      bpulse();
      expect_release("R10");

      // R8: widen to 64 KiB while one write is outstanding; 0xF000 now shares the window
      cfg_ctrl = mk(1'b1, 6'd16);
      send(32'h0000_F000, 0, "R8");
      bpulse();
      bpulse();

      // R9: index at or above the address width never halts
      cfg_ctrl = mk(1'b1, 6'd63);
      send(32'h0000_0000, 0, "R9");
      send(32'hFFFF_0000, 0, "R9");
      cfg_ctrl = mk(1'b1, 6'd32);
      send(32'h1234_5678, 0, "R9");
      repeat (3) bpulse();

      // R3: disabled gate passes window changes with writes outstanding
      cfg_ctrl = mk(1'b0, 6'd12);
      send(32'h0000_1000, 0, "R3");
      send(32'h0000_9000, 0, "R3");
      send(32'h0002_0000, 0, "R3");
      // R7: first write after enabling only records its window
      cfg_ctrl = mk(1'b1, 6'd12);
      send(32'h0004_0000, 0, "R7");
      hold_blocked(32'h0008_0000, 2, "R7");
      repeat (4) bpulse();
      expect_release("R7");
      bpulse();

      // R2: downstream stall is reflected upstream without losing the address
      m_awready = 1'b0;
      exp_q.push_back(32'h00AB_CDE0);
      s_awaddr  = 32'h00AB_CDE0;
      s_awvalid = 1'b1;
      #1;
      chk(m_awvalid && !s_awready, "R2", "stall pass-through", {m_awvalid, s_awready}, 2);
      chk(m_awaddr == 32'h00AB_CDE0, "R2", "address pass-through", m_awaddr, 32'h00AB_CDE0);
      tick();
      m_awready = 1'b1;
      #1;
      chk(s_awready, "R2", "ready follows downstream", s_awready, 1);
      tick();
      s_awvalid = 1'b0;
      bpulse();

      tick();
      chk(exp_q.size() == 0, "R2", "every write delivered", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule